// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is a 16-bit up-counter. A fixed divide-by-8 prescaler in front of it derives its steps from the system clock. Two 16-bit compare values are held in the block. When the count steps onto either compare value, the block emits a one-cycle request pulse on a dedicated output. An interrupt controller outside the block takes these pulses as flag bits 4 (compare 0) and 5 (compare 1) of its request word.

Software reaches the block through a byte-wide register bus:

| Address | Register |
|---|---|
| 0x10 / 0x11 | Compare 0, low / high byte |
| 0x12 / 0x13 | Compare 1, low / high byte |
| 0x14 | Clear-control register |
| 0x15 | Timer-control register |

Bit 3 of the clear-control register makes compare 1 act as the period of the count. Each match with compare 1 then restarts the count from zero. A zero period parks the counter at zero.

The timer-control register holds the run enable and a sticky overflow flag. The overflow flag is set when the count carries out of 16 bits. The running count is also driven on an output so that neighbouring logic can observe it.

Top module: `interval_timer16`

## Requirements
- R1: After reset the count is 0 and both request outputs are low. Compare bytes read 0x00, the clear-control register reads 0x10 and the timer-control register reads 0x00.
- R2: When timer-control bit 3 is set, the count rises by exactly one every 8 clock cycles. The first step lands on the 8th rising edge after the edge that wrote the enable.
- R3: When timer-control bit 3 is written as 0, the count returns to zero by the next edge and stays there. The prescaler phase also restarts, so a later enable again gives its first step after 8 edges.
- R4: `irq_cmp0` pulses high for one cycle in the cycle where the count first equals compare 0 (bytes 0x10 low, 0x11 high). It does not repeat while the count stays at that value.
- R5: `irq_cmp1` pulses high for one cycle when the count steps onto compare 1 (bytes 0x12 low, 0x13 high).
- R6: With clear-control bit 3 set and compare 1 nonzero, the step that would reach compare 1 yields zero instead. The count therefore runs 0 .. compare1-1. `irq_cmp1` still pulses on that step, and compare 0 keeps matching in every period.
- R7: With clear-control bit 3 set and compare 1 equal to zero, the count is held at zero and neither request pulses.
- R8: A step from 0xFFFF to 0x0000 sets timer-control bit 2. The bit stays set until software writes timer-control with bit 2 low.
- R9: Read data is registered: `bus_rdata` shows the register addressed in the previous cycle. Addresses outside 0x10..0x15 read 0x00.
- R10: Each compare byte is written alone; a write to one byte leaves the other byte of the same register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| irq_cmp0 | output | 1 | One-cycle request on compare 0 match |
| irq_cmp1 | output | 1 | One-cycle request on compare 1 match |
| tmr_count | output | 16 | Current count value |

## Verification
A prescaler phase that is off by one shows up on `tmr_count` as a step one cycle early or late. The bench sees this within eight cycles of an enable.

A fault in the compare path gives a request pulse that is missing, too wide, or that fires on a count other than the compare value. The bench sees this at the first match step.

If clear-on-match or hold-at-zero is mis-wired, the count climbs past the period or leaves zero. The bench sees this at the next step.

A wrong overflow flag stays hidden until the count wraps, so the fast-prescaler instance makes that wrap reachable within about 65 thousand cycles.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // timer-control register bit positions
  localparam int TCR_RUN_BIT  = 3;
  localparam int TCR_OVF_BIT  = 2;
  // clear-control register
  localparam int CCR_CLR_BIT  = 3;
  localparam logic [7:0] CCR_RESET = 8'h10;

  typedef struct packed {
    logic run;
    logic clr_on_cmp1;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int PRESC_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (PRESC_LOG2 == 0) begin : g_direct
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign tick = run;
    end else begin : g_div
      logic [PRESC_LOG2-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + 1'b1;
      end
      assign tick = run && (&phase);
    end
  endgenerate
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_ctl_t         ctl,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  output logic [CNT_W-1:0] count,
  output logic             irq0,
  output logic             irq1,
  output logic             carry
);
  logic [CNT_W:0] nxt;
  logic           hold, hit0, hit1, adv;

  assign nxt   = {1'b0, count} + 1'b1;
  assign hold  = ctl.clr_on_cmp1 && (cmp1 == '0);
  assign hit0  = (nxt[CNT_W-1:0] == cmp0);
  assign hit1  = (nxt[CNT_W-1:0] == cmp1);
  assign adv   = ctl.run && tick && !hold;
  assign carry = adv && nxt[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
    end else begin
      irq0 <= adv && hit0;
      irq1 <= adv && hit1;
      if (!ctl.run || hold)
        count <= '0;
      else if (tick)
        count <= (ctl.clr_on_cmp1 && hit1) ? '0 : nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          CNT_W    = 16,
  parameter int unsigned REG_BASE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              ovf_set,
  output tmr_ctl_t          ctl,
  output logic [CNT_W-1:0]  cmp0,
  output logic [CNT_W-1:0]  cmp1,
  output logic [7:0]        rdata
);
  localparam int NB = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] A_CMP1 = ADDR_W'(REG_BASE + NB);
  localparam logic [ADDR_W-1:0] A_CCR  = ADDR_W'(REG_BASE + 2 * NB);
  localparam logic [ADDR_W-1:0] A_TCR  = ADDR_W'(REG_BASE + 2 * NB + 1);

  logic [NB-1:0][7:0] c0_q, c1_q;
  logic [7:0]         ccr_q;
  logic               run_q, ovf_q;
  logic [7:0]         rd_mux;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          c0_q[b] <= 8'h00;
          c1_q[b] <= 8'h00;
        end else if (we) begin
          if (addr == A_CMP0 + ADDR_W'(b)) c0_q[b] <= wdata;
          if (addr == A_CMP1 + ADDR_W'(b)) c1_q[b] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q <= CCR_RESET;
      run_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (we && addr == A_CCR) ccr_q <= wdata;
      if (we && addr == A_TCR) begin
        run_q <= wdata[TCR_RUN_BIT];
        ovf_q <= wdata[TCR_OVF_BIT] | ovf_set;
      end else begin
        ovf_q <= ovf_q | ovf_set;
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (addr == A_CMP0 + ADDR_W'(i)) rd_mux = c0_q[i];
      if (addr == A_CMP1 + ADDR_W'(i)) rd_mux = c1_q[i];
    end
    if (addr == A_CCR) rd_mux = ccr_q;
    if (addr == A_TCR) begin
      rd_mux[TCR_RUN_BIT] = run_q;
      rd_mux[TCR_OVF_BIT] = ovf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_mux;
  end

  assign cmp0            = c0_q;
  assign cmp1            = c1_q;
  assign ctl.run         = run_q;
  assign ctl.clr_on_cmp1 = ccr_q[CCR_CLR_BIT];
endmodule

// File: rtl/interval_timer16.sv
module interval_timer16
  import tmr16_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          PRESC_LOG2 = 3,
  parameter int          ADDR_W     = 8,
  parameter int unsigned REG_BASE   = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_cmp0,
  output logic              irq_cmp1,
  output logic [CNT_W-1:0]  tmr_count
);
  tmr_ctl_t         ctl;
  logic             tick, carry;
  logic [CNT_W-1:0] cmp0_val, cmp1_val;

  tmr16_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_BASE(REG_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ovf_set(carry), .ctl(ctl), .cmp0(cmp0_val), .cmp1(cmp1_val),
    .rdata(bus_rdata)
  );

  tmr16_presc #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
    .clk(clk), .rst(rst), .run(ctl.run), .tick(tick)
  );

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .ctl(ctl), .tick(tick),
    .cmp0(cmp0_val), .cmp1(cmp1_val),
    .count(tmr_count), .irq0(irq_cmp0), .irq1(irq_cmp1), .carry(carry)
  );
endmodule

// File: rtl/interval_timer16_chk.sv
module interval_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             clr_en,
  input logic [CNT_W-1:0] cmp0,
  input logic [CNT_W-1:0] cmp1,
  input logic [CNT_W-1:0] count,
  input logic             irq0,
  input logic             irq1
);
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> (count == $past(count) + 1'b1) || (count == '0));

  // R3
  stop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));

  // R4
  irq0_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq0 |=> !irq0);

  // R4
  irq0_value_chk: assert property (@(posedge clk) disable iff (rst)
    (irq0 && $stable(cmp0)) |-> (count == cmp0) || (count == '0));

  // R5
  irq1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq1 |=> !irq1);

  // R7
  zero_period_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && cmp1 == '0) |=> (count == '0) && !irq0 && !irq1);
endmodule

bind interval_timer16 interval_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(ctl.run), .clr_en(ctl.clr_on_cmp1),
  .cmp0(cmp0_val), .cmp1(cmp1_val), .count(tmr_count),
  .irq0(irq_cmp0), .irq1(irq_cmp1)
);

// File: tb/test_interval_timer16.sv
module test_interval_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  rdata, f_rdata;
  logic        irq0, irq1, f_irq0, f_irq1;
  logic [15:0] count, f_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  interval_timer16 i_interval_timer16 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq_cmp0(irq0),
    .irq_cmp1(irq1), .tmr_count(count)
  );

  // same bus, prescaler bypassed so the 16-bit wrap is reachable
  interval_timer16 #(.PRESC_LOG2(0)) i_interval_timer16_fast (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(f_rdata), .irq_cmp0(f_irq0),
    .irq_cmp1(f_irq1), .tmr_count(f_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic [7:0] fd);
    bus_addr = a;
    @(negedge clk);
    d = rdata;
    fd = f_rdata;
  endtask

  // {is_write, req, addr, data}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'd10, 8'h10, 8'hA5},
    {1'b1, 4'd10, 8'h11, 8'h3C},
    {1'b0, 4'd10, 8'h10, 8'hA5},
    {1'b0, 4'd10, 8'h11, 8'h3C},
    {1'b1, 4'd10, 8'h10, 8'h01},
    {1'b0, 4'd10, 8'h11, 8'h3C},
    {1'b0, 4'd10, 8'h10, 8'h01},
    {1'b1, 4'd10, 8'h13, 8'h88},
    {1'b1, 4'd10, 8'h12, 8'h77},
    {1'b0, 4'd10, 8'h13, 8'h88},
    {1'b0, 4'd10, 8'h12, 8'h77},
    {1'b1, 4'd9,  8'h14, 8'h1A},
    {1'b0, 4'd9,  8'h14, 8'h1A},
    {1'b0, 4'd9,  8'h20, 8'h00},
    {1'b0, 4'd9,  8'h16, 8'h00}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, fd;
    int n0, n1, mx, bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 irqs", {irq0, irq1}, 0);
    rd(8'h14, d, fd); chk("R1 ccr", d, 8'h10);
    rd(8'h15, d, fd); chk("R1 tcr", d, 8'h00);
    rd(8'h11, d, fd); chk("R1 cmp0 hi", d, 8'h00);

    // R9 R10 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][15:8], VEC[i][7:0]);
      else begin
        rd(VEC[i][15:8], d, fd);
        chk($sformatf("R%0d table %0d", VEC[i][19:16], i), d, VEC[i][7:0]);
      end
    end

    // R4 R5 compare pulses, no clear
    wr(8'h14, 8'h10);
    wr(8'h10, 8'h03); wr(8'h11, 8'h00);
    wr(8'h12, 8'h05); wr(8'h13, 8'h00);
    wr(8'h15, 8'h08);
    n0 = 0; n1 = 0; bad = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (irq0) begin n0++; if (count != 16'd3) bad++; end
      if (irq1) begin n1++; if (count != 16'd5) bad++; end
    end
    chk("R4 irq_cmp0 pulses", n0, 1);
    chk("R5 irq_cmp1 pulses", n1, 1);
    chk("R4 R5 pulse at compare value", bad, 0);
    chk("R2 count after 60 cycles", count, 7);

    // R3 disable
    wr(8'h15, 8'h00);
    @(negedge clk);
    chk("R3 count zero after stop", count, 0);
    bad = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (count != 0) bad++;
    end
    chk("R3 count held while stopped", bad, 0);

    // R2 prescale timing, also phase restart (R3)
    wr(8'h15, 8'h08);
    repeat (7) @(negedge clk);
    chk("R2 no step before 8th edge", count, 0);
    @(negedge clk);
    chk("R2 first step on 8th edge", count, 1);
    repeat (8) @(negedge clk);
    chk("R2 second step", count, 2);
    wr(8'h15, 8'h00);

    // R6 clear on compare 1
    wr(8'h14, 8'h18);
    wr(8'h15, 8'h08);
    n0 = 0; n1 = 0; bad = 0; mx = 0;
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
      if (irq0) n0++;
      if (irq1) begin n1++; if (count != 0) bad++; end
    end
    chk("R6 highest count", mx, 4);
    chk("R6 irq_cmp1 per period", n1, 2);
    chk("R6 irq_cmp0 per period", n0, 2);
    chk("R6 count zero at cmp1 pulse", bad, 0);
    wr(8'h15, 8'h00);

    // R7 zero period holds
    wr(8'h12, 8'h00); wr(8'h13, 8'h00);
    wr(8'h15, 8'h08);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (count != 0 || irq0 || irq1) bad++;
    end
    chk("R7 held at zero, no requests", bad, 0);
    wr(8'h15, 8'h00);
    wr(8'h14, 8'h10);

    // R8 overflow on the fast instance
    wr(8'h15, 8'h08);
    repeat (65000) @(negedge clk);
    rd(8'h15, d, fd); chk("R8 no overflow yet", fd, 8'h08);
    repeat (600) @(negedge clk);
    rd(8'h15, d, fd); chk("R8 overflow set", fd, 8'h0C);
    repeat (10) @(negedge clk);
    rd(8'h15, d, fd); chk("R8 overflow sticky", fd, 8'h0C);
    wr(8'h15, 8'h08);
    rd(8'h15, d, fd); chk("R8 overflow cleared by write", fd, 8'h08);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule